// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit AES ciphertext block into plaintext using a 128-bit key. Key, ciphertext and plaintext all cross the boundary as 32-bit words. Each word has a 2-bit word address. The datapath is one column wide. Each round is built one column per clock into a shadow register, so a whole block takes eleven round-key applications of four columns each: 44 cycles.

The key port takes the last round key of the forward expansion, round key 10. The block derives the earlier round keys itself by running the key expansion backwards. It keeps the key as loaded, so the next block starts from round key 10 again without a reload.

The three lower ciphertext words sit in a staging buffer that may be rewritten while a block is in flight. Writing the top word while the input is ready starts the block. The result is copied into a separate output buffer and leaves it as four strobed words.

Top module: `aes_dec_core`

## Requirements
- R1: Word address 3 carries the first four bytes of the AES block and address 0 carries the last four. Inside a word, bits 31:24 hold the byte that comes first in the block. This applies to the key, the ciphertext and the plaintext ports alike.
- R2: When `ct_load` is high with `ct_addr` = 3 while `in_ready` is high, a decryption starts at that clock edge. `in_ready` is low from the next cycle.
- R3: After a start edge, `in_ready` stays low for exactly 44 cycles and is high again after the 44th following rising edge.
- R4: `key_busy` is high exactly while `in_ready` is low. Any key write made while it is high leaves the stored key unchanged, and the next block decrypts with the earlier key.
- R5: On the same edge that `in_ready` returns high, `pt_valid` rises. It stays high for four consecutive cycles with `pt_addr` running 0, 1, 2, 3, and then falls.
- R6: With round key 10 of key 000102030405060708090a0b0c0d0e0f loaded, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a yields plaintext 00112233445566778899aabbccddeeff. The result follows standard AES-128 decryption: an initial key addition, nine full inverse rounds and a final round without the column mix.
- R7: Lower ciphertext words (addresses 0 to 2) may be written at any time. A write made during a decryption does not affect that block's result, and it is used by the next block.
- R8: A write of word 3 while `in_ready` is low starts nothing and its data is never used.
- R9: A block started while the previous plaintext is still being strobed leaves those four output words unchanged.
- R10: After asynchronous reset, `in_ready` = 1, `key_busy` = 0, `pt_valid` = 0, `pt_addr` = 0 and `pt_word` = 0.
- R11: The loaded key stays in effect for later blocks without being loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| key_load | input | 1 | Write strobe for a key word |
| key_addr | input | 2 | Key word address |
| key_word | input | 32 | Key word (round key 10) |
| key_busy | output | 1 | High while key writes are refused |
| ct_load | input | 1 | Write strobe for a ciphertext word |
| ct_addr | input | 2 | Ciphertext word address, 3 starts a block |
| ct_word | input | 32 | Ciphertext word |
| in_ready | output | 1 | High when word 3 of a new block is accepted |
| pt_valid | output | 1 | Plaintext word strobe |
| pt_addr | output | 2 | Plaintext word address |
| pt_word | output | 32 | Plaintext word |

## Verification
The hardest case to reach is three things overlapping. A new block starts in the very first cycle `in_ready` returns, while the previous plaintext is still leaving the output buffer. In the same window, the staging words and the key port have been written during the busy time. The stimulus gets there in several steps. It refills the lower words and writes a stray key and a stray top word while the block runs. It then polls `in_ready` at each falling edge and fires word 3 in the first ready cycle. A cycle-accurate model predicts the status outputs and every strobed word across the overlap.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

   typedef logic [7:0]       byte_t;
   typedef logic [31:0]      word_t;
   typedef logic [3:0][31:0] block_t;   // index = AES column

   localparam byte_t RCON_TOP = 8'h36;

   function automatic byte_t gf_mul(byte_t a, byte_t b);
      byte_t p;
      byte_t x;
      p = '0;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      end
      return p;
   endfunction

   // a^254 is the field inverse (0 maps to 0)
   function automatic byte_t gf_inv(byte_t a);
      byte_t p;
      byte_t r;
      p = a;
      r = 8'h01;
      for (int i = 0; i < 7; i++) begin
         p = gf_mul(p, p);
         r = gf_mul(r, p);
      end
      return r;
   endfunction

   function automatic byte_t rotl8(byte_t b, int n);
      byte_t t;
      t = b;
      for (int i = 0; i < n; i++) t = {t[6:0], t[7]};
      return t;
   endfunction

   function automatic byte_t sbox_fwd(byte_t a);
      byte_t b;
      b = gf_inv(a);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction

   function automatic byte_t sbox_inv(byte_t a);
      return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
   endfunction

   function automatic word_t sub_word(word_t w);
      return {sbox_fwd(w[31:24]), sbox_fwd(w[23:16]), sbox_fwd(w[15:8]), sbox_fwd(w[7:0])};
   endfunction

   function automatic word_t inv_mix(word_t w);
      byte_t a0, a1, a2, a3;
      a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
      return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
              gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
              gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
              gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
   endfunction

   // round constant one step lower (inverse of xtime)
   function automatic byte_t rcon_down(byte_t r);
      return (r == 8'h1b) ? 8'h80 : {1'b0, r[7:1]};
   endfunction

   // round key i -> round key i-1
   function automatic block_t key_prev(block_t k, byte_t rc);
      block_t p;
      p[3] = k[3] ^ k[2];
      p[2] = k[2] ^ k[1];
      p[1] = k[1] ^ k[0];
      p[0] = k[0] ^ sub_word({p[3][23:0], p[3][31:24]}) ^ {rc, 24'h0};
      return p;
   endfunction

endpackage

// File: rtl/aes_dec_inbuf.sv
module aes_dec_inbuf
   import aes_dec_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NCOL   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              accept,
   output logic              start,
   output block_t            blk
);
   localparam logic [1:0] TOP_ADDR = 2'(NCOL - 1);

   logic [NCOL-2:0][WORD_W-1:0] stage;

   for (genvar a = 0; a < NCOL - 1; a++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                                  stage[a] <= '0;
         else if (wr_en && wr_addr == 2'(a))       stage[a] <= wr_data;
      end
   end

   assign start  = wr_en && (wr_addr == TOP_ADDR) && accept;
   assign blk[0] = wr_data;
   for (genvar c = 1; c < NCOL; c++) begin : g_col
      assign blk[c] = stage[NCOL-1-c];
   end

endmodule

// File: rtl/aes_dec_keysched.sv
module aes_dec_keysched
   import aes_dec_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NCOL   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              key_wr,
   input  logic [1:0]        key_addr,
   input  logic [WORD_W-1:0] key_data,
   input  logic              lock,
   input  logic              start,
   input  logic              step,
   output block_t            rkey
);
   block_t kin;
   block_t kwork;
   byte_t  rcon;

   for (genvar c = 0; c < NCOL; c++) begin : g_kin
      always_ff @(posedge clk or posedge rst) begin
         if (rst) kin[c] <= '0;
         else if (key_wr && !lock && key_addr == 2'(NCOL-1-c)) kin[c] <= key_data;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         kwork <= '0;
         rcon  <= RCON_TOP;
      end else if (start) begin
         kwork <= kin;
         rcon  <= RCON_TOP;
      end else if (step) begin
         kwork <= key_prev(kwork, rcon);
         rcon  <= rcon_down(rcon);
      end
   end

   assign rkey = kwork;

   assert_key_locked_R4: assert property (@(posedge clk) disable iff (rst)
      (lock && key_wr) |=> $stable(kin));

endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
   import aes_dec_pkg::*;
#(
   parameter int NCOL = 4
) (
   input  block_t     st,
   input  block_t     rk,
   input  logic [1:0] col,
   input  logic       is_init,
   input  logic       do_mix,
   output word_t      col_out
);
   word_t subbed;
   word_t added;

   // inverse row shift: row r of column col comes from column col-r
   for (genvar r = 0; r < NCOL; r++) begin : g_row
      logic [1:0] src;
      assign src = col - 2'(r);
      assign subbed[31-8*r -: 8] = sbox_inv(st[src][31-8*r -: 8]);
   end

   assign added   = (is_init ? st[col] : subbed) ^ rk[col];
   assign col_out = do_mix ? inv_mix(added) : added;

endmodule

// File: rtl/aes_dec_outstage.sv
module aes_dec_outstage
   import aes_dec_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NCOL   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  block_t            data,
   output logic              valid,
   output logic [1:0]        addr,
   output logic [WORD_W-1:0] word
);
   localparam logic [1:0] LAST_IDX = 2'(NCOL - 1);

   logic [NCOL-1:0][WORD_W-1:0] swapped;
   logic [NCOL-1:0][WORD_W-1:0] obuf;
   logic [1:0]                  idx;
   logic                        act;

   for (genvar a = 0; a < NCOL; a++) begin : g_swap
      assign swapped[a] = data[NCOL-1-a];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         obuf <= '0;
         idx  <= '0;
         act  <= 1'b0;
      end else if (load) begin
         obuf <= swapped;
         idx  <= '0;
         act  <= 1'b1;
      end else if (act) begin
         idx <= (idx == LAST_IDX) ? 2'd0 : idx + 2'd1;
         act <= (idx != LAST_IDX);
      end
   end

   assign valid = act;
   assign addr  = idx;
   assign word  = obuf[idx];

   assert_strobe_order_R5: assert property (@(posedge clk) disable iff (rst)
      (valid && addr != LAST_IDX) |=> (valid && addr == 2'($past(addr) + 2'd1)));

   assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (valid && addr != LAST_IDX) |=> $stable(obuf));

endmodule

// File: rtl/aes_dec_core.sv
module aes_dec_core
   import aes_dec_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int NCOL    = 4,
   parameter int NROUNDS = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              key_load,
   input  logic [1:0]        key_addr,
   input  logic [WORD_W-1:0] key_word,
   output logic              key_busy,
   input  logic              ct_load,
   input  logic [1:0]        ct_addr,
   input  logic [WORD_W-1:0] ct_word,
   output logic              in_ready,
   output logic              pt_valid,
   output logic [1:0]        pt_addr,
   output logic [WORD_W-1:0] pt_word
);
   localparam int          RND_W    = $clog2(NROUNDS + 1);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NROUNDS);
   localparam logic [1:0]  LAST_COL = 2'(NCOL - 1);

   if (WORD_W != 32) begin : g_bad_word
      $error("aes_dec_core: WORD_W must be 32");
   end
   if (NCOL != 4) begin : g_bad_col
      $error("aes_dec_core: NCOL must be 4");
   end
   if (NROUNDS != 10) begin : g_bad_rnd
      $error("aes_dec_core: only 10 rounds (128-bit key) supported");
   end

   logic                       busy;
   logic [RND_W-1:0]           rnd;
   logic [1:0]                 col;
   block_t                     st;
   logic [NCOL-2:0][WORD_W-1:0] nx;
   logic                       start;
   block_t                     in_blk;
   block_t                     rkey;
   word_t                      col_out;
   logic                       step;
   logic                       done;
   block_t                     result;

   aes_dec_inbuf #(.WORD_W(WORD_W), .NCOL(NCOL)) u_inbuf (
      .clk(clk), .rst(rst), .wr_en(ct_load), .wr_addr(ct_addr), .wr_data(ct_word),
      .accept(in_ready), .start(start), .blk(in_blk));

   aes_dec_keysched #(.WORD_W(WORD_W), .NCOL(NCOL)) u_keys (
      .clk(clk), .rst(rst), .key_wr(key_load), .key_addr(key_addr), .key_data(key_word),
      .lock(busy), .start(start), .step(step), .rkey(rkey));

   aes_dec_round #(.NCOL(NCOL)) u_round (
      .st(st), .rk(rkey), .col(col),
      .is_init(rnd == '0), .do_mix(rnd != '0 && rnd != LAST_RND),
      .col_out(col_out));

   assign step   = busy && (col == LAST_COL);
   assign done   = step && (rnd == LAST_RND);
   assign result = {col_out, nx};

   for (genvar c = 0; c < NCOL - 1; c++) begin : g_nx
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                         nx[c] <= '0;
         else if (busy && col == 2'(c))   nx[c] <= col_out;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         busy <= 1'b0;
         rnd  <= '0;
         col  <= '0;
         st   <= '0;
      end else if (start) begin
         busy <= 1'b1;
         rnd  <= '0;
         col  <= '0;
         st   <= in_blk;
      end else if (busy) begin
         col <= col + 2'd1;
         if (step) begin
            st  <= result;
            rnd <= rnd + 1'b1;
            if (done) busy <= 1'b0;
         end
      end
   end

   assign in_ready = !busy;
   assign key_busy = busy;

   aes_dec_outstage #(.WORD_W(WORD_W), .NCOL(NCOL)) u_out (
      .clk(clk), .rst(rst), .load(done), .data(result),
      .valid(pt_valid), .addr(pt_addr), .word(pt_word));

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
      (ct_load && ct_addr == LAST_COL && in_ready) |=> !in_ready);

   assert_done_strobe_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (pt_valid && pt_addr == 2'd0));

   assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst)
      busy |-> (rnd <= LAST_RND));

endmodule

// File: tb/aes_dec_core_test.sv
`timescale 1ns/1ps
module aes_dec_core_test;

   localparam logic [127:0] K1 = 128'h13111d7fe3944a17f307a78b4d2b30c5;
   localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
   localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
   localparam logic [127:0] K2 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
   localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
   localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
   localparam logic [127:0] KX = 128'hdeadbeef0badf00dcafebabe12345678;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        key_load = 1'b0;
   logic [1:0]  key_addr = '0;
   logic [31:0] key_word = '0;
   logic        ct_load = 1'b0;
   logic [1:0]  ct_addr = '0;
   logic [31:0] ct_word = '0;
   logic        key_busy, in_ready, pt_valid;
   logic [1:0]  pt_addr;
   logic [31:0] pt_word;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit running = 0;
   string phase = "R10";

   // reference model state
   int           m_cnt = 0;
   bit           m_valid = 0;
   int           m_idx = 0;
   logic [127:0] m_word = '0;
   logic [127:0] m_pend = '0;
   logic [127:0] pend = '0;

   always #4 clk = ~clk;

   aes_dec_core uut (
      .clk(clk), .rst(rst), .key_load(key_load), .key_addr(key_addr), .key_word(key_word),
      .key_busy(key_busy), .ct_load(ct_load), .ct_addr(ct_addr), .ct_word(ct_word),
      .in_ready(in_ready), .pt_valid(pt_valid), .pt_addr(pt_addr), .pt_word(pt_word));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) act=%h exp=%h at cycle %0d", req, phase, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // model: advances on each rising edge from the inputs held since the last falling edge
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
      if (!rst) begin
         if (m_valid) begin
            if (m_idx == 3) begin m_valid = 0; m_idx = 0; end
            else m_idx++;
         end
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_valid = 1; m_idx = 0; m_word = m_pend; end
         end else if (ct_load && ct_addr == 2'd3) begin
            m_cnt = 44;          // R2 start, R3 44-cycle budget
            m_pend = pend;
         end
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (running) begin
         chk("R3", {31'b0, in_ready}, {31'b0, m_cnt == 0});
         chk("R4", {31'b0, key_busy}, {31'b0, m_cnt != 0});
         chk("R5", {31'b0, pt_valid}, {31'b0, m_valid});
         if (m_valid) begin
            chk("R5", {30'b0, pt_addr}, m_idx[31:0]);
            chk("R6", pt_word, m_word[32*m_idx +: 32]);
         end
      end
   end

   task automatic put_key(input logic [127:0] k);
      for (int a = 0; a < 4; a++) begin
         key_load = 1'b1; key_addr = 2'(a); key_word = k[32*a +: 32];
         @(negedge clk);
      end
      key_load = 1'b0;
   endtask

   task automatic send_lower(input logic [127:0] c);
      for (int a = 0; a < 3; a++) begin
         ct_load = 1'b1; ct_addr = 2'(a); ct_word = c[32*a +: 32];
         @(negedge clk);
      end
      ct_load = 1'b0;
   endtask

   task automatic fire(input logic [127:0] c, input logic [127:0] p);
      while (!in_ready) @(negedge clk);
      pend = p;
      ct_load = 1'b1; ct_addr = 2'd3; ct_word = c[127:96];
      @(negedge clk);
      ct_load = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_cnt != 0 || m_valid) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values
      chk("R10", {31'b0, in_ready}, 32'd1);
      chk("R10", {31'b0, key_busy}, 32'd0);
      chk("R10", {31'b0, pt_valid}, 32'd0);
      chk("R10", {30'b0, pt_addr}, 32'd0);
      chk("R10", pt_word, 32'd0);
      rst = 1'b0;
      running = 1;
      @(negedge clk);

      phase = "R6";                  // standard vector
      put_key(K1);
      send_lower(C1);
      fire(C1, P1);
      chk("R2", {31'b0, in_ready}, 32'd0);
      wait_idle();

      phase = "R11";                 // key and lower words kept
      fire(C1, P1);
      wait_idle();

      phase = "R1";                  // second vector, other byte patterns
      put_key(K2);
      send_lower(C2);
      fire(C2, P2);
      wait_idle();

      phase = "R7";                  // lower words rewritten during a block
      put_key(K1);
      send_lower(C1);
      fire(C1, P1);
      send_lower(C2);
      while (!in_ready) @(negedge clk);
      put_key(K2);
      fire(C2, P2);
      wait_idle();

      phase = "R4";                  // stray key and stray word 3 while busy
      fire(C2, P2);
      put_key(KX);
      phase = "R8";
      ct_load = 1'b1; ct_addr = 2'd3; ct_word = 32'hffff0000;
      @(negedge clk);
      ct_load = 1'b0;
      chk("R8", {31'b0, in_ready}, 32'd0);
      phase = "R9";                  // starts land during output strobes
      fire(C2, P2);
      fire(C2, P2);
      wait_idle();

      finish_run();
   end

endmodule